// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

A small programmable logic cell of the kind found in a complex PLD. Eighteen inputs feed an AND plane of product terms; each product term is the AND of any chosen true or complemented inputs. Twenty of those terms feed four macrocells. Each macrocell either ORs any chosen subset of the twenty terms and can XOR the sum with its own fifth term, or takes a fast route that ORs only its own four terms. The result can leave the cell directly or through a flip-flop.

Three further product terms serve as controls. The first can act as the register clock in place of one of three global clocks. The second can clear the registers. The third can drive the output enable. The cell is set up by one wide static configuration vector, which is held constant while the cell operates. An active-low global reset clears all registers asynchronously.

Top module: `ptlb_top`

## Requirements
- R1: Product term p is the AND of the literals enabled in the 36-bit mask at cfg_i[p*36 +: 36]. Bit 2i selects input i true and bit 2i+1 selects input i complemented. An all-zero mask gives 1, and a mask that selects both literals of one input gives 0. Terms 0..19 are data terms, 20 is the clock term, 21 the reset term and 22 the enable term.
- R2: Macrocell k has a 23-bit field at cfg_i[828+23k +: 23]. On the wide route, its bits [19:0] choose which data terms are ORed into the sum.
- R3: When field bit 20 is 1 on the wide route, the sum is XORed with term 5k+4.
- R4: When field bit 21 is 1, the output is the OR of terms 5k..5k+3 only. The share bits and the XOR bit then have no effect.
- R5: When field bit 22 is 0, out_o[k] follows the logic combinationally. When it is 1, out_o[k] changes only on a rising edge of the block clock.
- R6: cfg_i[921:920] selects the block clock: 0, 1 or 2 picks gclk_i[0], gclk_i[1] or gclk_i[2], and 3 picks term 20. Edges on the clocks that are not selected have no effect.
- R7: While rst_n_i is low, all registers read 0 at once, whatever the clock is doing.
- R8: When cfg_i[922] is 1, term 21 high clears the registers asynchronously. When cfg_i[922] is 0, term 21 has no effect.
- R9: When cfg_i[923] is 1, oe_o equals term 22. When it is 0, oe_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_i | input | 18 | Input vector to the AND plane |
| gclk_i | input | 3 | Global clocks |
| rst_n_i | input | 1 | Asynchronous active-low global reset |
| cfg_i | input | 924 | Static configuration vector |
| out_o | output | 4 | Macrocell outputs |
| oe_o | output | 1 | Output enable |

## Verification
Combinational outputs and oe_o are due in the same time step as an input change. The bench therefore samples them 1 ns after it drives the inputs, away from any clock edge. A registered output is due right after the rising edge of the selected clock. The bench first checks it once before that edge, to show that the old value holds, and then again 1 ns after the edge. The two resets act without a clock, so the bench checks them 1 ns after it drives the reset, between edges.

// File: rtl/ptlb_pkg.sv
`timescale 1ns/1ps
package ptlb_pkg;
  typedef enum logic [1:0] {CLK_G0 = 2'd0, CLK_G1 = 2'd1, CLK_G2 = 2'd2, CLK_PT = 2'd3} clk_src_e;
  typedef struct packed {
    logic reg_en;
    logic byp;
    logic xor_en;
  } mc_mode_t;
endpackage

// File: rtl/ptlb_and_plane.sv
`timescale 1ns/1ps
module ptlb_and_plane #(
  parameter int N_IN = 18,
  parameter int NPT  = 23
) (
  input  logic                    chk_clk_i,
  input  logic                    rst_n_i,
  input  logic [N_IN-1:0]         in_i,
  input  logic [NPT*2*N_IN-1:0]   mask_i,
  output logic [NPT-1:0]          pt_o
);
  localparam int MW = 2 * N_IN;

  function automatic logic pt_eval(input logic [MW-1:0] m, input logic [N_IN-1:0] x);
    logic r;
    r = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (m[2*i] && !x[i])   r = 1'b0;
      if (m[2*i+1] && x[i])  r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic has_conflict(input logic [MW-1:0] m);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N_IN; i++) r = r | (m[2*i] & m[2*i+1]);
    return r;
  endfunction

  for (genvar p = 0; p < NPT; p++) begin : g_pt
    logic conflict;
    assign pt_o[p]  = pt_eval(mask_i[p*MW +: MW], in_i);
    assign conflict = has_conflict(mask_i[p*MW +: MW]);
    // R1
    conflict_false_chk: assert property (@(posedge chk_clk_i) disable iff (!rst_n_i)
      conflict |-> !pt_o[p]);
  end
endmodule

// File: rtl/ptlb_clk_sel.sv
`timescale 1ns/1ps
module ptlb_clk_sel
  import ptlb_pkg::*;
(
  input  logic [2:0] gclk_i,
  input  logic       pt_clk_i,
  input  clk_src_e   sel_i,
  output logic       blk_clk_o
);
  always_comb begin
    case (sel_i)
      CLK_G0:  blk_clk_o = gclk_i[0];
      CLK_G1:  blk_clk_o = gclk_i[1];
      CLK_G2:  blk_clk_o = gclk_i[2];
      default: blk_clk_o = pt_clk_i;
    endcase
  end
endmodule

// File: rtl/ptlb_macrocell.sv
`timescale 1ns/1ps
module ptlb_macrocell
  import ptlb_pkg::*;
#(
  parameter int NSUM      = 20,
  parameter int PT_PER_MC = 5,
  parameter int IDX       = 0
) (
  input  logic            chk_clk_i,
  input  logic            rst_n_i,
  input  logic [NSUM-1:0] pt_i,
  input  logic [NSUM-1:0] share_i,
  input  mc_mode_t        mode_i,
  input  logic            blk_clk_i,
  input  logic            clr_i,
  output logic            out_o
);
  localparam int NBYP = PT_PER_MC - 1;

  function automatic logic wide_sum(input logic [NSUM-1:0] pts, input logic [NSUM-1:0] sel,
                                    input logic xe, input logic xt);
    return (|(pts & sel)) ^ (xe & xt);
  endfunction

  logic [PT_PER_MC-1:0] own;
  logic                 byp_sum, wide, d, q;

  assign own     = pt_i[IDX*PT_PER_MC +: PT_PER_MC];
  assign byp_sum = |own[NBYP-1:0];
  assign wide    = wide_sum(pt_i, share_i, mode_i.xor_en, own[PT_PER_MC-1]);
  assign d       = mode_i.byp ? byp_sum : wide;

  always_ff @(posedge blk_clk_i or posedge clr_i) begin
    if (clr_i) q <= 1'b0;
    else       q <= d;
  end

  assign out_o = mode_i.reg_en ? q : d;

  // R7 R8
  clr_reg_zero_chk: assert property (@(posedge chk_clk_i) disable iff (!rst_n_i)
    (clr_i && mode_i.reg_en) |-> !out_o);
  // R4
  byp_no_terms_chk: assert property (@(posedge chk_clk_i) disable iff (!rst_n_i)
    (mode_i.byp && own[NBYP-1:0] == '0) |-> !d);
endmodule

// File: rtl/ptlb_top.sv
`timescale 1ns/1ps
module ptlb_top
  import ptlb_pkg::*;
#(
  parameter int N_IN      = 18,
  parameter int N_MC      = 4,
  parameter int PT_PER_MC = 5,
  localparam int NSUM     = N_MC * PT_PER_MC,
  localparam int NPT      = NSUM + 3,
  localparam int MW       = 2 * N_IN,
  localparam int MC_W     = NSUM + 3,
  localparam int MC_BASE  = NPT * MW,
  localparam int G_BASE   = MC_BASE + N_MC * MC_W,
  localparam int CFG_W    = G_BASE + 4
) (
  input  logic [N_IN-1:0]  in_i,
  input  logic [2:0]       gclk_i,
  input  logic             rst_n_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [N_MC-1:0]  out_o,
  output logic             oe_o
);
  localparam int PT_CLK = NSUM;
  localparam int PT_RST = NSUM + 1;
  localparam int PT_OE  = NSUM + 2;

  logic [NPT-1:0] pt;
  logic           blk_clk, clr, rst_en, oe_en;
  clk_src_e       clk_sel;

  assign clk_sel = clk_src_e'(cfg_i[G_BASE +: 2]);
  assign rst_en  = cfg_i[G_BASE + 2];
  assign oe_en   = cfg_i[G_BASE + 3];

  ptlb_and_plane #(.N_IN(N_IN), .NPT(NPT)) u_plane (
    .chk_clk_i (gclk_i[0]),
    .rst_n_i   (rst_n_i),
    .in_i      (in_i),
    .mask_i    (cfg_i[MC_BASE-1:0]),
    .pt_o      (pt)
  );

  ptlb_clk_sel u_clk (
    .gclk_i    (gclk_i),
    .pt_clk_i  (pt[PT_CLK]),
    .sel_i     (clk_sel),
    .blk_clk_o (blk_clk)
  );

  assign clr = !rst_n_i || (rst_en && pt[PT_RST]);

  for (genvar k = 0; k < N_MC; k++) begin : g_mc
    localparam int B = MC_BASE + k * MC_W;
    ptlb_macrocell #(.NSUM(NSUM), .PT_PER_MC(PT_PER_MC), .IDX(k)) u_mc (
      .chk_clk_i (gclk_i[0]),
      .rst_n_i   (rst_n_i),
      .pt_i      (pt[NSUM-1:0]),
      .share_i   (cfg_i[B +: NSUM]),
      .mode_i    (mc_mode_t'(cfg_i[B+NSUM +: 3])),
      .blk_clk_i (blk_clk),
      .clr_i     (clr),
      .out_o     (out_o[k])
    );
  end

  assign oe_o = oe_en ? pt[PT_OE] : 1'b1;

  // R9
  oe_default_chk: assert property (@(posedge gclk_i[0]) disable iff (!rst_n_i)
    !oe_en |-> oe_o);
endmodule

// File: tb/tb_ptlb_top.sv
`timescale 1ns/1ps
module tb_ptlb_top;
  localparam int NI = 18, MW = 36, NPT = 23, MCB = NPT * MW, MCW = 23;
  localparam int GB = MCB + 4 * MCW, CW = GB + 4;

  logic clk = 1'b0, g1 = 1'b0, g2 = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] x = '0;
  logic [CW-1:0] cfg = '0;
  logic [3:0] out;
  logic oe;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ptlb_top dut (.in_i(x), .gclk_i({g2, g1, clk}), .rst_n_i(rst_n), .cfg_i(cfg), .out_o(out), .oe_o(oe));

  function automatic logic m_pt(int p, logic [NI-1:0] v);
    logic r = 1'b1;
    for (int i = 0; i < NI; i++)
      if ((cfg[p*MW+2*i] && !v[i]) || (cfg[p*MW+2*i+1] && v[i])) r = 1'b0;
    return r;
  endfunction

  function automatic logic [3:0] m_out(logic [NI-1:0] v);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) begin
      int b = MCB + k * MCW;
      logic s = 1'b0;
      if (cfg[b+21]) begin
        for (int j = 0; j < 4; j++) s = s | m_pt(5*k+j, v);
      end else begin
        for (int j = 0; j < 20; j++) if (cfg[b+j]) s = s | m_pt(j, v);
        if (cfg[b+20]) s = s ^ m_pt(5*k+4, v);
      end
      r[k] = s;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rand_pts(int lim);
    for (int p = 0; p < 20; p++) begin
      cfg[p*MW +: MW] = '0;
      for (int j = 0; j <= int'($urandom % 3); j++)
        cfg[p*MW + 2*int'($urandom % lim) + int'($urandom % 2)] = 1'b1;
    end
  endtask

  task automatic set_mc(int k, logic [19:0] sh, logic xe, logic bp, logic rg);
    cfg[MCB + k*MCW +: MCW] = {rg, bp, xe, sh};
  endtask

  task automatic set_glob(logic [1:0] sel, logic re, logic oen);
    cfg[GB +: 4] = {oen, re, sel};
  endtask

  task automatic pulse(int j);
    #1;
    if (j == 1) g1 = 1'b1; else g2 = 1'b1;
    #1;
    g1 = 1'b0; g2 = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    rand_pts(NI);
    for (int k = 0; k < 4; k++) set_mc(k, 20'hFFFFF, 1'b1, 1'b0, 1'b1);
    set_glob(2'd0, 1'b0, 1'b0);
    x = 18'h2AAAA;
    repeat (3) @(posedge clk);
    #1 chk("R7 regs zero in reset", out, 4'h0);
    chk("R9 oe default high", {3'b0, oe}, 4'h1);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_literal;
    @(negedge clk);
    cfg = '0;
    cfg[5*MW+6] = 1'b1; cfg[5*MW+7] = 1'b1;
    cfg[10*MW+10] = 1'b1; cfg[10*MW+15] = 1'b1;
    set_mc(0, 20'h00001, 0, 0, 0);
    set_mc(1, 20'h00020, 0, 0, 0);
    set_mc(2, 20'h00400, 0, 0, 0);
    set_mc(3, 20'h00000, 0, 0, 0);
    for (int n = 0; n < 8; n++) begin
      x = 18'($urandom);
      #1 chk("R1 literal encoding", out, {1'b0, x[5] & !x[7], 1'b0, 1'b1});
    end
  endtask

  task automatic t_comb(logic xe, string tag);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      rand_pts(NI);
      for (int k = 0; k < 4; k++) set_mc(k, 20'($urandom & $urandom & $urandom), xe, 1'b0, 1'b0);
      for (int n = 0; n < 10; n++) begin
        x = 18'($urandom);
        #1 chk(tag, out, m_out(x));
      end
    end
  endtask

  task automatic t_bypass;
    @(negedge clk);
    cfg = '0;
    for (int p = 0; p < 4; p++) begin cfg[p*MW] = 1'b1; cfg[p*MW+1] = 1'b1; end
    set_mc(0, 20'h00020, 1, 1, 0);
    set_mc(1, 20'h00000, 0, 1, 0);
    #1 chk("R4 bypass ignores share and xor", out, 4'b0010);
    for (int c = 0; c < 4; c++) begin
      rand_pts(NI);
      for (int k = 0; k < 4; k++) set_mc(k, 20'($urandom), 1'($urandom), 1'b1, 1'b0);
      for (int n = 0; n < 8; n++) begin
        x = 18'($urandom);
        #1 chk("R4 bypass random", out, m_out(x));
      end
    end
  endtask

  task automatic t_reg_g0;
    logic [3:0] prev;
    @(negedge clk);
    rand_pts(NI);
    for (int k = 0; k < 4; k++) set_mc(k, 20'($urandom & $urandom), 1'($urandom), 1'($urandom), 1'b1);
    set_glob(2'd0, 1'b0, 1'b0);
    x = 18'($urandom);
    @(posedge clk);
    prev = m_out(x);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      x = 18'($urandom);
      #1 chk("R5 hold until edge", out, prev);
      @(posedge clk);
      #1 chk("R5 update on edge", out, m_out(x));
      prev = m_out(x);
    end
  endtask

  task automatic t_sel(int j);
    logic [3:0] ea;
    @(negedge clk);
    rand_pts(NI);
    for (int k = 0; k < 4; k++) set_mc(k, 20'($urandom & $urandom), 1'b1, 1'b0, 1'b1);
    set_glob(2'(j), 1'b0, 1'b0);
    x = 18'($urandom);
    pulse(j);
    ea = m_out(x);
    chk("R6 selected clock captures", out, ea);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      x = 18'($urandom);
      pulse(3 - j);
      @(posedge clk);
      #1 chk("R6 other clocks ignored", out, ea);
      @(negedge clk);
      pulse(j);
      ea = m_out(x);
      chk("R6 selected clock", out, ea);
    end
  endtask

  task automatic t_ptclk;
    logic [3:0] ea;
    @(negedge clk);
    rand_pts(16);
    cfg[20*MW +: MW] = '0;
    cfg[20*MW + 34] = 1'b1;
    for (int k = 0; k < 4; k++) set_mc(k, 20'($urandom & $urandom), 1'($urandom), 1'b0, 1'b1);
    set_glob(2'd3, 1'b0, 1'b0);
    for (int n = 0; n < 5; n++) begin
      x[17] = 1'b0;
      x[15:0] = 16'($urandom);
      #2 x[17] = 1'b1;
      ea = m_out(x);
      #1 chk("R6 term clock rising", out, ea);
      @(posedge clk);
      #2 x[15:0] = 16'($urandom);
      #1 x[17] = 1'b0;
      #1 chk("R6 term clock falling ignored", out, ea);
    end
  endtask

  task automatic ones_cfg(logic re);
    cfg = '0;
    for (int k = 0; k < 4; k++) set_mc(k, 20'(1) << (5*k), 1'b0, 1'b0, 1'b1);
    cfg[21*MW + 32] = 1'b1;
    set_glob(2'd0, re, 1'b0);
  endtask

  task automatic t_ptrst;
    @(negedge clk);
    ones_cfg(1'b1);
    x = '0;
    @(posedge clk);
    #1 chk("R8 loaded before term reset", out, 4'hF);
    @(negedge clk) x[16] = 1'b1;
    #1 chk("R8 term reset clears at once", out, 4'h0);
    @(posedge clk);
    #1 chk("R8 term reset holds over edge", out, 4'h0);
    @(negedge clk) x[16] = 1'b0;
    @(posedge clk);
    #1 chk("R8 reload after term reset", out, 4'hF);
    @(negedge clk) set_glob(2'd0, 1'b0, 1'b0);
    x[16] = 1'b1;
    #1 chk("R8 term reset disabled", out, 4'hF);
    @(posedge clk);
    #1 chk("R8 term reset disabled over edge", out, 4'hF);
  endtask

  task automatic t_grst;
    @(negedge clk);
    ones_cfg(1'b0);
    x = '0;
    @(posedge clk);
    #1 chk("R7 loaded", out, 4'hF);
    #2 rst_n = 1'b0;
    #1 chk("R7 global reset clears at once", out, 4'h0);
    @(posedge clk);
    #1 chk("R7 held through edge", out, 4'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 chk("R7 reload after release", out, 4'hF);
  endtask

  task automatic t_oe;
    @(negedge clk);
    cfg[22*MW +: MW] = '0;
    cfg[22*MW + 5] = 1'b1;
    cfg[22*MW + 18] = 1'b1;
    set_glob(2'd0, 1'b0, 1'b1);
    for (int n = 0; n < 8; n++) begin
      x = 18'($urandom);
      #1 chk("R9 oe from term", {3'b0, oe}, {3'b0, !x[2] & x[9]});
    end
    set_glob(2'd0, 1'b0, 1'b0);
    x[2] = 1'b1;
    #1 chk("R9 oe forced high", {3'b0, oe}, 4'h1);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_literal();
    t_comb(1'b0, "R2 wide sum");
    t_comb(1'b1, "R3 wide sum with xor");
    t_bypass();
    t_reg_g0();
    t_sel(1);
    t_sel(2);
    t_ptclk();
    t_ptrst();
    t_grst();
    t_oe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule